// File: doc/BRIEF.md
# Aperture Address Remapping Table

This block remaps addresses that fall inside a fixed input window, 4 KB page by 4 KB page, onto physical pages. Each page of the window owns one 32-bit table entry. Bit 31 of an entry marks it valid, and bits 30 to 12 give the physical frame. Software never addresses the table directly. It first writes the input address of a page into a selector register. It then writes or reads a data register to store or fetch that page's entry. A control register switches translation on and off.

Client logic presents an input address on the lookup port, together with the offset of the last byte it will touch. The block answers with the physical address, made from the entry's frame and the low 12 bits of the input. It raises a fault instead when translation is off, when either end of the access lies outside the window, or when the page's entry is not valid. The window base, the page count and whether the lookup result is registered are all elaboration parameters.

Top module: `aperture_remap`

## Requirements
- R1: After reset, translation is disabled, every table entry reads as zero, the selector register reads as zero and every lookup faults.
- R2: Register offsets are 0x0 (control, bit 0 = translation enable), 0x4 (page selector, reads back the value written) and 0x8 (entry data). A read of any other offset returns zero, and a write to any other offset changes nothing.
- R3: A write to offset 0x8 stores the full 32-bit write value as the entry of the page named by the selector.
- R4: A read returns its data with `bus_rvalid` high exactly one cycle after the `bus_rd` cycle. A read of offset 0x8 returns the stored entry of the selected page.
- R5: Writing 1 to bit 0 of the control register enables translation, and writing 0 disables it. A control read returns the effect of every write accepted in an earlier cycle, so it can serve as a read-back flush.
- R6: The page index of a lookup is (address − window base) >> 12. For an entry with bit 31 set, the result is {1'b0, entry[30:12], address[11:0]} with no fault, and entry bits 11:0 play no part in it.
- R7: While translation is disabled, every lookup faults.
- R8: A lookup of a page whose entry has bit 31 clear, including a zero entry, faults without `lk_oor`.
- R9: A lookup faults with `lk_oor` set when its first byte (`lk_addr`) or its last byte (`lk_addr + lk_last_ofs`) lies outside base to base + PAGE_COUNT×4096 − 1.
- R10: The selector's low 12 bits are ignored when it picks a page. When the selector lies outside the window, entry-data writes change no entry and entry-data reads return zero.
- R11: With REG_OUT = 1, the result appears with `lk_done` one cycle after the `lk_valid` cycle. With REG_OUT = 0, it appears in the same cycle. `lk_phys` is zero whenever `lk_fault` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup input address (first byte) |
| lk_last_ofs | input | 12 | Offset of the last byte of the access from lk_addr |
| lk_done | output | 1 | Lookup result valid |
| lk_phys | output | 32 | Translated physical address |
| lk_fault | output | 1 | Lookup failed (disabled, out of window or invalid entry) |
| lk_oor | output | 1 | Lookup failed because the access leaves the window |

## Verification
The bench builds the block with a window base of 0x4000_0000, PAGE_COUNT = 16 and REG_OUT = 1. The small page count puts the top page, the first address past the window and an access that crosses the upper edge within a few bus writes. It also allows the bench's own model of the table to stay small. The registered lookup lets a queued scoreboard match each result against an expectation that was pushed one cycle earlier.

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter logic [31:0] WIN_BASE   = 32'h4000_0000,
  parameter int          PAGE_COUNT = 64,
  parameter bit          REG_OUT    = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic        bus_rvalid,
  output logic [31:0] bus_rdata,
  input  logic        lk_valid,
  input  logic [31:0] lk_addr,
  input  logic [11:0] lk_last_ofs,
  output logic        lk_done,
  output logic [31:0] lk_phys,
  output logic        lk_fault,
  output logic        lk_oor
);
  localparam int          IDX_W   = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;
  localparam logic [32:0] BASE_X  = {1'b0, WIN_BASE};
  localparam logic [32:0] END_X   = BASE_X + 33'(PAGE_COUNT) * 33'd4096;
  localparam logic [3:0]  OFS_CTL = 4'h0;
  localparam logic [3:0]  OFS_SEL = 4'h4;
  localparam logic [3:0]  OFS_ENT = 4'h8;

  logic             enable;
  logic [31:0]      sel_addr;
  logic [31:0]      tbl [PAGE_COUNT];

  logic             sel_in;
  logic [IDX_W-1:0] sel_idx;
  assign sel_in  = ({1'b0, sel_addr} >= BASE_X) && ({1'b0, sel_addr} < END_X);
  assign sel_idx = IDX_W'((sel_addr - WIN_BASE) >> 12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      sel_addr <= '0;
      for (int i = 0; i < PAGE_COUNT; i++) tbl[i] <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_CTL: enable   <= bus_wdata[0];
        OFS_SEL: sel_addr <= bus_wdata;
        OFS_ENT: if (sel_in) tbl[sel_idx] <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        case (bus_addr)
          OFS_CTL: bus_rdata <= {31'b0, enable};
          OFS_SEL: bus_rdata <= sel_addr;
          OFS_ENT: bus_rdata <= sel_in ? tbl[sel_idx] : 32'h0;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  logic [32:0]      lk_last;
  logic [IDX_W-1:0] lk_idx;
  logic [31:0]      lk_ent;
  logic             oor_c, fault_c;
  logic [31:0]      phys_c;

  assign lk_last = {1'b0, lk_addr} + {21'b0, lk_last_ofs};
  assign oor_c   = ({1'b0, lk_addr} < BASE_X) || ({1'b0, lk_addr} >= END_X) || (lk_last >= END_X);
  assign lk_idx  = IDX_W'((lk_addr - WIN_BASE) >> 12);
  assign lk_ent  = oor_c ? 32'h0 : tbl[lk_idx];
  assign fault_c = oor_c || !enable || !lk_ent[31];
  assign phys_c  = fault_c ? 32'h0 : {1'b0, lk_ent[30:12], lk_addr[11:0]};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lk_done  <= 1'b0;
          lk_phys  <= '0;
          lk_fault <= 1'b0;
          lk_oor   <= 1'b0;
        end else begin
          lk_done  <= lk_valid;
          lk_phys  <= lk_valid ? phys_c : 32'h0;
          lk_fault <= lk_valid && fault_c;
          lk_oor   <= lk_valid && oor_c;
        end
      end

      AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done) else $error("lookup result missing"); // R11
      AST_DISABLED_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !enable) |=> lk_fault) else $error("disabled lookup passed"); // R7
    end else begin : g_comb
      assign lk_done  = lk_valid;
      assign lk_phys  = lk_valid ? phys_c : 32'h0;
      assign lk_fault = lk_valid && fault_c;
      assign lk_oor   = lk_valid && oor_c;
    end
  endgenerate

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid) else $error("read data missing"); // R4
  AST_CTL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CTL) |=> (enable == $past(bus_wdata[0]))) else $error("control lost"); // R5
  AST_OOR_IS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_oor) |-> lk_fault) else $error("oor without fault"); // R9
  AST_FAULT_NO_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_fault) |-> (lk_phys == 32'h0)) else $error("faulted phys nonzero"); // R11
endmodule

// File: tb/aperture_remap_bench.sv
module aperture_remap_bench;
  localparam logic [31:0] BASE  = 32'h4000_0000;
  localparam int          PAGES = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [11:0] lk_last_ofs = '0;
  logic        lk_done, lk_fault, lk_oor;
  logic [31:0] lk_phys;

  always #5 clk = ~clk;

  aperture_remap #(.WIN_BASE(BASE), .PAGE_COUNT(PAGES), .REG_OUT(1'b1)) u_aperture_remap (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_last_ofs(lk_last_ofs),
    .lk_done(lk_done), .lk_phys(lk_phys), .lk_fault(lk_fault), .lk_oor(lk_oor));

  int checks = 0, errors = 0;
  bit done_flag = 0;

  logic [31:0] m_tbl [PAGES];
  logic        m_en = 0;
  logic [31:0] m_sel = 0;

  logic [31:0] rq_exp [$];
  string       rq_tag [$];
  logic [33:0] lq_exp [$];
  string       lq_tag [$];

  function automatic bit in_win(input logic [32:0] a);
    return (a >= {1'b0, BASE}) && (a < {1'b0, BASE} + 33'(PAGES * 4096));
  endfunction

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    if (a == 4'h0) m_en = d[0];
    else if (a == 4'h4) m_sel = d;
    else if (a == 4'h8 && in_win({1'b0, m_sel})) m_tbl[(m_sel - BASE) >> 12] = d;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic reg_read(input logic [3:0] a, input string tag);
    logic [31:0] e;
    if (a == 4'h0) e = {31'b0, m_en};
    else if (a == 4'h4) e = m_sel;
    else if (a == 4'h8) e = in_win({1'b0, m_sel}) ? m_tbl[(m_sel - BASE) >> 12] : 32'h0;
    else e = 32'h0;
    rq_exp.push_back(e); rq_tag.push_back(tag);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic [11:0] ofs, input string tag);
    logic oor, flt; logic [31:0] ent, ph;
    oor = !in_win({1'b0, a}) || !in_win({1'b0, a} + {21'b0, ofs});
    ent = oor ? 32'h0 : m_tbl[(a - BASE) >> 12];
    flt = oor || !m_en || !ent[31];
    ph  = flt ? 32'h0 : {1'b0, ent[30:12], a[11:0]};
    lq_exp.push_back({flt, oor, ph}); lq_tag.push_back(tag);
    lk_valid = 1; lk_addr = a; lk_last_ofs = ofs;
    @(negedge clk);
    lk_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      if (bus_rvalid) begin
        checks++;
        if (rq_exp.size() == 0) begin
          errors++; $display("FAIL R4: unexpected read data %h expected none", bus_rdata);
        end else begin
          logic [31:0] e; string t;
          e = rq_exp.pop_front(); t = rq_tag.pop_front();
          if (bus_rdata !== e) begin
            errors++; $display("FAIL %s: read %h expected %h", t, bus_rdata, e);
          end
        end
      end
      if (lk_done) begin
        checks++;
        if (lq_exp.size() == 0) begin
          errors++; $display("FAIL R11: unexpected lookup result %h expected none", lk_phys);
        end else begin
          logic [33:0] e; string t;
          e = lq_exp.pop_front(); t = lq_tag.pop_front();
          if ({lk_fault, lk_oor, lk_phys} !== e) begin
            errors++;
            $display("FAIL %s: got fault=%b oor=%b phys=%h expected fault=%b oor=%b phys=%h",
                     t, lk_fault, lk_oor, lk_phys, e[33], e[32], e[31:0]);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < PAGES; i++) m_tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    reg_read(4'h0, "R1 control after reset");
    reg_read(4'h4, "R1 selector after reset");
    reg_read(4'h8, "R1 entry after reset");
    lookup(BASE, 12'h0, "R1 lookup after reset");
    // R3 R4: program page 3 with nonzero low bits
    reg_write(4'h4, BASE + 32'h3000);
    reg_write(4'h8, 32'h8001_2ABC);
    reg_read(4'h8, "R3 R4 entry read back");
    lookup(BASE + 32'h3123, 12'h0, "R7 disabled lookup");
    reg_write(4'h0, 32'h1);
    reg_read(4'h0, "R5 control flush read");
    lookup(BASE + 32'h3123, 12'h0, "R6 translate page 3");
    lookup(BASE + 32'h3FF8, 12'h7, "R6 page end");
    lookup(BASE + 32'h5000, 12'h0, "R8 unmapped page");
    // R9 boundaries on the top page
    reg_write(4'h4, BASE + 32'hF000);
    reg_write(4'h8, 32'h8ABC_D000);
    lookup(BASE + 32'hFFF0, 12'hF, "R9 last byte at window end");
    lookup(BASE + 32'hFFF0, 12'h10, "R9 last byte past window");
    lookup(BASE - 32'h1, 12'h0, "R9 below window");
    lookup(BASE + 32'h1_0000, 12'h0, "R9 first byte past window");
    // R10 unaligned selector and out-of-window selector
    reg_write(4'h4, BASE + 32'h37FC);
    reg_read(4'h8, "R10 unaligned selector read");
    reg_write(4'h4, BASE + 32'h10_0000);
    reg_write(4'h8, 32'h8000_0000);
    reg_read(4'h8, "R10 out-of-window read");
    lookup(BASE, 12'h0, "R10 ignored write left page 0 unmapped");
    reg_read(4'h4, "R2 selector read back");
    // R2 unused offset
    reg_write(4'hC, 32'hFFFF_FFFF);
    reg_read(4'hC, "R2 unused offset reads zero");
    reg_read(4'h0, "R2 unused write left control");
    // R8 unmap page 3
    reg_write(4'h4, BASE + 32'h3000);
    reg_write(4'h8, 32'h0);
    lookup(BASE + 32'h3123, 12'h0, "R8 unmapped after clear");
    reg_write(4'h0, 32'h0);
    reg_read(4'h0, "R5 disable read");
    lookup(BASE + 32'hF010, 12'h0, "R7 disabled after clear");
    repeat (4) @(negedge clk);
    checks++;
    if (rq_exp.size() != 0 || lq_exp.size() != 0) begin
      errors++;
      $display("FAIL R4 R11: %0d reads and %0d lookups unanswered, expected 0", rq_exp.size(), lq_exp.size());
    end
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule